// File: doc/BRIEF.md
# DRAM Random-Cycle Timing Sequencer

This block runs single random read and write cycles on a fast-page-mode or extended-data-out DRAM. A requestor holds `req` with an address, a direction and write data. The sequencer acknowledges the request and then drives the row-strobe, column-strobe and write-enable lines. It also drives the multiplexed address, with a select that shows whether row or column is on the bus. When the cycle ends it returns read data together with a one-tick done pulse.

All phase lengths come from one 6-bit timing register, written through its own port. The block runs on a clock at twice the memory-clock rate, so one memory clock is two ticks. This makes a one-and-a-half-clock precharge an ordinary three-tick count. The register is never changed while a cycle is running. A write that arrives while the sequencer is busy is parked and applied on the first idle tick.

Top module: `dram_timing_seq`

## Requirements
- R1: After reset all strobes are high (inactive), `done` and `ack` are low, and the timing register reads as all zeros, i.e. a 5-clock cycle, 2-clock row-to-column delay and 2-clock precharge.
- R2: With requests back to back and no turnaround, the spacing between successive row-strobe falls is max(2·N, D + 2 + P) ticks. N is 5, 4 or 3 for cycle code (register bits 6:5) 00, 01 or 10.
- R3: Register bit 4 sets the row-to-column delay D: 0 gives 4 ticks, 1 gives 2 ticks. The row half (`req_addr` upper half) is on `dram_addr` with `dram_col_sel`=0 when the row strobe falls. The column half is on the bus with `dram_col_sel`=1 from the column-strobe fall.
- R4: Register bits 3:2 set the precharge P, the row-strobe high time between cycles: 00 gives 4 ticks, 01 gives 3, 10 gives 2, 11 gives 4.
- R5: The column strobe is low for max(2·N − P − D, 2) ticks and is never low while the row strobe is high. Both strobes rise on the same tick.
- R6: A write that directly follows a read gets extra row-strobe high time before it. With FPM (`edo_mode`=0) this is 2 ticks whatever bit 7 holds. With EDO it is 4 ticks when bit 7 is 0 and 2 ticks when bit 7 is 1. Other sequences get no extra time.
- R7: Reads return `dram_dq_in` as it was on the last tick of column-strobe low (FPM), or on the first tick after the column strobe rises (EDO). `rd_data` holds that value while `done` is high.
- R8: Each cycle produces exactly one `done` pulse and one `ack` pulse, each one tick long. For a write, `done` comes on the tick the strobes rise.
- R9: During a write, `dram_we_n` is low and `dram_dq_oe` is high with `dram_dq_out` equal to the request's write data, for the whole row-strobe low time. Write-enable is never low while the row strobe is high.
- R10: A timing write made while a cycle runs does not affect that cycle. The last such write is applied on the first idle tick, and no request is accepted on that tick, so the following gap is one tick longer.
- R11: A timing write whose cycle code (bits 6:5) is 11 is ignored and leaves the timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, twice the memory-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| edo_mode | input | 1 | 1 selects EDO memory, 0 selects FPM; change only when idle |
| req | input | 1 | Cycle request, held until `ack` |
| req_we | input | 1 | 1 for a write cycle, 0 for a read |
| req_addr | input | 2*AW | Row address in the upper half, column in the lower half |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-tick pulse when the request is taken |
| cfg_we | input | 1 | Timing register write strobe |
| cfg_wdata | input | 6 (bits 7:2) | Timing value: bit 7 EDO turnaround, 6:5 cycle code, 4 row-to-column delay, 3:2 precharge |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_col_sel | output | 1 | 0 while the row is on `dram_addr`, 1 for the column |
| dram_dq_out | output | DW | Data driven during writes |
| dram_dq_oe | output | 1 | Output enable for `dram_dq_out` |
| dram_dq_in | input | DW | Data returned by the memory |
| rd_data | output | DW | Captured read data, valid with `done` |
| done | output | 1 | One-tick end-of-cycle pulse |

## Verification
Two things can land on the same idle tick: a parked timing write being applied, and a waiting request being accepted. The bench provokes this by holding `req` high across two reads and issuing two timing writes while the first read is still running. It judges the result at the strobes. The first cycle must keep its old row-to-column delay, the precharge gap must be exactly one tick longer than the old precharge, and the second cycle's delay must match the later of the two written values.

// File: rtl/dts_pkg.sv
package dts_pkg;
  localparam int TICK_W = 4;   // width of phase counters, in half-clock ticks
  localparam int TPM    = 2;   // ticks per memory clock
  localparam int MIN_CAS = 2;  // shortest column-strobe low time, ticks
  localparam int CFG_HI = 7;
  localparam int CFG_LO = 2;
  localparam int NRC_HI = 6;
  localparam int NRC_LO = 5;
  localparam int RCD_B  = 4;
  localparam int PRE_HI = 3;
  localparam int PRE_LO = 2;
  localparam int TURN_B = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_RCD, ST_CAS, ST_PRE
  } seq_state_t;

  typedef struct packed {
    logic [TICK_W-1:0] rcd;
    logic [TICK_W-1:0] cas;
    logic [TICK_W-1:0] pre;
    logic [TICK_W-1:0] turn;
  } tick_plan_t;
endpackage

// File: rtl/dts_cfg.sv
module dts_cfg
  import dts_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               busy,
  input  logic               wr_en,
  input  logic [CFG_HI:CFG_LO] wr_data,
  output logic [CFG_HI:CFG_LO] cfg_q,
  output logic               apply
);
  logic                 pend_v;
  logic [CFG_HI:CFG_LO] pend_d;
  logic                 legal;

  assign legal = (wr_data[NRC_HI:NRC_LO] != 2'b11);
  assign apply = !busy && ((wr_en && legal) || pend_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      pend_v <= 1'b0;
      pend_d <= '0;
    end else if (!busy) begin
      pend_v <= 1'b0;
      if (wr_en && legal) cfg_q <= wr_data;
      else if (pend_v)    cfg_q <= pend_d;
    end else if (wr_en && legal) begin
      pend_v <= 1'b1;
      pend_d <= wr_data;
    end
  end

  AST_CFG_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cfg_q)); // R10
  AST_PEND_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (!busy && pend_v) |=> !pend_v); // R10
  AST_NRC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cfg_q[NRC_HI:NRC_LO] != 2'b11); // R11
endmodule

// File: rtl/dts_timing.sv
module dts_timing
  import dts_pkg::*;
(
  input  logic                 edo,
  input  logic [CFG_HI:CFG_LO] cfg,
  output tick_plan_t           plan
);
  logic [TICK_W:0]   rc_t;
  logic [TICK_W-1:0] rcd_t, pre_t, cas_t, turn_t;

  always_comb begin
    unique case (cfg[NRC_HI:NRC_LO])
      2'b01:   rc_t = (TICK_W+1)'(4 * TPM);
      2'b10:   rc_t = (TICK_W+1)'(3 * TPM);
      default: rc_t = (TICK_W+1)'(5 * TPM);
    endcase
    rcd_t = cfg[RCD_B] ? TICK_W'(TPM) : TICK_W'(2 * TPM);
    unique case (cfg[PRE_HI:PRE_LO])
      2'b01:   pre_t = TICK_W'(TPM + 1);
      2'b10:   pre_t = TICK_W'(TPM);
      default: pre_t = TICK_W'(2 * TPM);
    endcase
    if (rc_t > ({1'b0, pre_t} + {1'b0, rcd_t} + (TICK_W+1)'(MIN_CAS - 1)))
      cas_t = TICK_W'(rc_t - {1'b0, pre_t} - {1'b0, rcd_t});
    else
      cas_t = TICK_W'(MIN_CAS);
    if (edo && !cfg[TURN_B]) turn_t = TICK_W'(2 * TPM);
    else                     turn_t = TICK_W'(TPM);
    plan.rcd  = rcd_t;
    plan.cas  = cas_t;
    plan.pre  = pre_t;
    plan.turn = turn_t;
  end
endmodule

// File: rtl/dts_seq.sv
module dts_seq
  import dts_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edo,
  input  logic          hold,
  input  tick_plan_t    plan,
  input  logic          req,
  input  logic          req_we,
  input  logic [2*AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic          busy,
  output logic          ack,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic          col_sel,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rd_data,
  output logic          done
);
  seq_state_t        st;
  logic [TICK_W-1:0] cnt;
  logic              last_rd, edo_cap, cur_we;
  logic [AW-1:0]     col_q;
  logic              accept;

  assign busy   = (st != ST_IDLE);
  assign accept = (st == ST_IDLE) && req && !hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  cnt <= '0;
      ras_n <= 1'b1;  cas_n <= 1'b1;  we_n <= 1'b1;
      addr <= '0;     col_q <= '0;    col_sel <= 1'b0;
      dq_out <= '0;   dq_oe <= 1'b0;  rd_data <= '0;
      ack <= 1'b0;    done <= 1'b0;
      last_rd <= 1'b0; edo_cap <= 1'b0; cur_we <= 1'b0;
    end else begin
      ack     <= 1'b0;
      done    <= 1'b0;
      edo_cap <= 1'b0;
      if (edo_cap) begin
        rd_data <= dq_in;
        done    <= 1'b1;
        last_rd <= 1'b1;
      end
      unique case (st)
        ST_IDLE: if (accept) begin
          ack     <= 1'b1;
          cur_we  <= req_we;
          addr    <= req_addr[2*AW-1:AW];
          col_q   <= req_addr[AW-1:0];
          col_sel <= 1'b0;
          dq_out  <= req_wdata;
          if (last_rd && req_we) begin
            st  <= ST_TURN;
            cnt <= plan.turn - TICK_W'(1);
          end else begin
            st    <= ST_RCD;
            cnt   <= plan.rcd - TICK_W'(1);
            ras_n <= 1'b0;
            we_n  <= !req_we;
            dq_oe <= req_we;
          end
        end
        ST_TURN: if (cnt == '0) begin
          st    <= ST_RCD;
          cnt   <= plan.rcd - TICK_W'(1);
          ras_n <= 1'b0;
          we_n  <= !cur_we;
          dq_oe <= cur_we;
        end else cnt <= cnt - TICK_W'(1);
        ST_RCD: if (cnt == '0) begin
          st      <= ST_CAS;
          cnt     <= plan.cas - TICK_W'(1);
          cas_n   <= 1'b0;
          col_sel <= 1'b1;
          addr    <= col_q;
        end else cnt <= cnt - TICK_W'(1);
        ST_CAS: if (cnt == '0) begin
          st    <= ST_PRE;
          cnt   <= plan.pre - TICK_W'(2);
          ras_n <= 1'b1;
          cas_n <= 1'b1;
          we_n  <= 1'b1;
          dq_oe <= 1'b0;
          if (cur_we || !edo) begin
            done    <= 1'b1;
            last_rd <= !cur_we;
            if (!cur_we) rd_data <= dq_in;
          end else begin
            edo_cap <= 1'b1;
          end
        end else cnt <= cnt - TICK_W'(1);
        ST_PRE: if (cnt == '0) st <= ST_IDLE;
                else cnt <= cnt - TICK_W'(1);
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n); // R5
  AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $rose(cas_n) |-> $rose(ras_n)); // R5
  AST_ROW_AT_RAS_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> !col_sel); // R3
  AST_WE_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (!ras_n && dq_oe)); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R8
  AST_NO_ACCEPT_ON_APPLY: assert property (@(posedge clk) disable iff (rst)
    hold |=> !ack); // R10
endmodule

// File: rtl/dram_timing_seq.sv
module dram_timing_seq
  import dts_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 edo_mode,
  input  logic                 req,
  input  logic                 req_we,
  input  logic [2*AW-1:0]      req_addr,
  input  logic [DW-1:0]        req_wdata,
  output logic                 ack,
  input  logic                 cfg_we,
  input  logic [CFG_HI:CFG_LO] cfg_wdata,
  output logic                 dram_ras_n,
  output logic                 dram_cas_n,
  output logic                 dram_we_n,
  output logic [AW-1:0]        dram_addr,
  output logic                 dram_col_sel,
  output logic [DW-1:0]        dram_dq_out,
  output logic                 dram_dq_oe,
  input  logic [DW-1:0]        dram_dq_in,
  output logic [DW-1:0]        rd_data,
  output logic                 done
);
  logic                 busy, apply;
  logic [CFG_HI:CFG_LO] cfg_q;
  tick_plan_t           plan;

  dts_cfg u_cfg (
    .clk(clk), .rst(rst), .busy(busy), .wr_en(cfg_we),
    .wr_data(cfg_wdata), .cfg_q(cfg_q), .apply(apply)
  );

  dts_timing u_timing (
    .edo(edo_mode), .cfg(cfg_q), .plan(plan)
  );

  dts_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst(rst), .edo(edo_mode), .hold(apply), .plan(plan),
    .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .dq_in(dram_dq_in), .busy(busy), .ack(ack),
    .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
    .addr(dram_addr), .col_sel(dram_col_sel),
    .dq_out(dram_dq_out), .dq_oe(dram_dq_oe),
    .rd_data(rd_data), .done(done)
  );
endmodule

// File: tb/tb_dram_timing_seq.sv
module tb_dram_timing_seq;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int TL = 128;
  localparam logic [AW-1:0] ROW1 = 10'h2A5, COL1 = 10'h15A;
  localparam logic [AW-1:0] ROW2 = 10'h0F3, COL2 = 10'h30C;
  localparam logic [DW-1:0] WD1 = 16'hBEEF, WD2 = 16'h1234;
  // {cfg[7:0], edo, first_is_write, second_is_write}
  localparam logic [10:0] VEC [8] = '{
    {8'h00, 1'b0, 1'b0, 1'b0},
    {8'h20, 1'b0, 1'b0, 1'b1},
    {8'h40, 1'b1, 1'b0, 1'b0},
    {8'h14, 1'b1, 1'b0, 1'b1},
    {8'h98, 1'b1, 1'b0, 1'b1},
    {8'h9C, 1'b0, 1'b0, 1'b1},
    {8'h38, 1'b1, 1'b1, 1'b0},
    {8'h54, 1'b0, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic edo_mode = 1'b0, req = 1'b0, req_we = 1'b0, cfg_we = 1'b0;
  logic [2*AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, dram_dq_in = '0;
  logic [7:2] cfg_wdata = '0;
  logic ack, dram_ras_n, dram_cas_n, dram_we_n, dram_col_sel, dram_dq_oe, done;
  logic [AW-1:0] dram_addr;
  logic [DW-1:0] dram_dq_out, rd_data;

  dram_timing_seq #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst(rst), .edo_mode(edo_mode), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_col_sel(dram_col_sel),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in),
    .rd_data(rd_data), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // trace recorder: samples on the falling edge, then drives dq_in = index+100
  logic tr_ras[TL], tr_cas[TL], tr_we[TL], tr_done[TL], tr_col[TL], tr_oe[TL];
  logic [AW-1:0] tr_addr[TL];
  logic [DW-1:0] tr_rd[TL], tr_dq[TL];
  int idx = 0;
  bit trace_on = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (trace_on && idx < TL) begin
        tr_ras[idx] = dram_ras_n;  tr_cas[idx] = dram_cas_n;
        tr_we[idx]  = dram_we_n;   tr_done[idx] = done;
        tr_col[idx] = dram_col_sel; tr_oe[idx] = dram_dq_oe;
        tr_addr[idx] = dram_addr;  tr_rd[idx] = rd_data; tr_dq[idx] = dram_dq_out;
      end
      dram_dq_in = DW'(idx + 100);
      if (trace_on) idx++;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  function automatic int x_rcd(input logic [7:0] c); return c[4] ? 2 : 4; endfunction
  function automatic int x_pre(input logic [7:0] c);
    case (c[3:2]) 2'b01: return 3; 2'b10: return 2; default: return 4; endcase
  endfunction
  function automatic int x_rc(input logic [7:0] c);
    case (c[6:5]) 2'b01: return 8; 2'b10: return 6; default: return 10; endcase
  endfunction
  function automatic int x_cas(input logic [7:0] c);
    int b;
    b = x_rc(c) - x_pre(c) - x_rcd(c);
    return (b < 2) ? 2 : b;
  endfunction
  function automatic int x_turn(input logic [7:0] c, input bit e);
    return (e && !c[7]) ? 4 : 2;
  endfunction

  int r0, c0, e0, r1, c1, d0;
  task automatic analyse();
    r0 = -1; c0 = -1; e0 = -1; r1 = -1; c1 = -1; d0 = -1;
    for (int i = 0; i < TL; i++) begin
      if (r0 < 0 && tr_ras[i] == 1'b0) r0 = i;
      else if (r0 >= 0 && c0 < 0 && tr_cas[i] == 1'b0) c0 = i;
      else if (c0 >= 0 && e0 < 0 && tr_ras[i] == 1'b1) e0 = i;
      else if (e0 >= 0 && r1 < 0 && tr_ras[i] == 1'b0) r1 = i;
      else if (r1 >= 0 && c1 < 0 && tr_cas[i] == 1'b0) c1 = i;
      if (d0 < 0 && tr_done[i] == 1'b1) d0 = i;
    end
  endtask

  task automatic wait_ack();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (ack) break;
    end
  endtask

  task automatic cfg_write(input logic [7:0] c);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = c[7:2];
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic trace_start();
    @(posedge clk); #2; idx = 0; trace_on = 1'b1;
  endtask

  task automatic run_pair(input bit w1, input bit w2);
    trace_start();
    @(negedge clk);
    req = 1'b1; req_we = w1; req_addr = {ROW1, COL1}; req_wdata = WD1;
    wait_ack();
    req_we = w2; req_addr = {ROW2, COL2}; req_wdata = WD2;
    wait_ack();
    req = 1'b0;
    repeat (24) @(negedge clk);
    trace_on = 1'b0;
    analyse();
  endtask

  task automatic check_cycle(input logic [7:0] c, input bit e, input bit w1, input bit w2);
    int tn, base;
    tn = (!w1 && w2) ? x_turn(c, e) : 0;
    base = (x_rc(c) > x_rcd(c) + 2 + x_pre(c)) ? x_rc(c) : x_rcd(c) + 2 + x_pre(c);
    chk(c0 - r0 == x_rcd(c), "R3 row-to-column delay", c0 - r0, x_rcd(c));
    chk(tr_addr[r0] == ROW1 && tr_col[r0] == 1'b0, "R3 row on bus at row strobe", int'(tr_addr[r0]), int'(ROW1));
    chk(tr_addr[c0] == COL1 && tr_col[c0] == 1'b1, "R3 column on bus at column strobe", int'(tr_addr[c0]), int'(COL1));
    chk(e0 - c0 == x_cas(c), "R5 column strobe width", e0 - c0, x_cas(c));
    chk(tr_cas[e0] == 1'b1, "R5 strobes rise together", int'(tr_cas[e0]), 1);
    if (tn != 0) chk(r1 - e0 == x_pre(c) + tn, "R6 read-to-write gap", r1 - e0, x_pre(c) + tn);
    else         chk(r1 - e0 == x_pre(c), "R4 precharge", r1 - e0, x_pre(c));
    chk(r1 - r0 == base + tn, "R2 cycle spacing", r1 - r0, base + tn);
    chk(tr_addr[r1] == ROW2, "R3 second row", int'(tr_addr[r1]), int'(ROW2));
    if (!w1) begin
      chk(d0 == (e ? e0 + 1 : e0), "R7 capture tick", d0, e ? e0 + 1 : e0);
      chk(int'(tr_rd[d0]) == d0 - 1 + 100, "R7 read data", int'(tr_rd[d0]), d0 - 1 + 100);
    end else begin
      int lows;
      lows = 0;
      for (int i = r0; i < e0; i++) if (tr_we[i] == 1'b0 && tr_oe[i] == 1'b1) lows++;
      chk(lows == e0 - r0, "R9 write enable over row strobe", lows, e0 - r0);
      chk(tr_dq[c0] == WD1, "R9 write data", int'(tr_dq[c0]), int'(WD1));
      chk(d0 == e0, "R8 write done tick", d0, e0);
    end
    chk(tr_done[d0 + 1] == 1'b0, "R8 done one tick", int'(tr_done[d0 + 1]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1 strobes idle after reset",
        int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
    chk(!done && !ack, "R1 no pulses after reset", int'({done, ack}), 0);

    // R1: default timing before any register write
    run_pair(1'b0, 1'b0);
    chk(c0 - r0 == 4 && e0 - c0 == 2 && r1 - e0 == 4, "R1 default timing", r1 - r0, 10);
    check_cycle(8'h00, 1'b0, 1'b0, 1'b0);

    // table walk
    for (int v = 0; v < 8; v++) begin
      logic [7:0] c;
      c = VEC[v][10:3];
      edo_mode = VEC[v][2];
      cfg_write(c);
      run_pair(VEC[v][1], VEC[v][0]);
      check_cycle(c, VEC[v][2], VEC[v][1], VEC[v][0]);
    end

    // R11: reserved cycle code ignored, 0x54 stays in force
    edo_mode = 1'b0;
    cfg_write(8'h60);
    run_pair(1'b0, 1'b0);
    chk(c0 - r0 == 2, "R11 delay kept", c0 - r0, 2);
    chk(r1 - e0 == 3, "R11 precharge kept", r1 - e0, 3);
    chk(r1 - r0 == 7, "R11 spacing kept", r1 - r0, 7);

    // R10: writes during a running read; last one wins, applied on an idle tick
    trace_start();
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = {ROW1, COL1};
    wait_ack();
    cfg_we = 1'b1; cfg_wdata = 6'(8'h98 >> 2);
    @(negedge clk); cfg_wdata = 6'(8'h00 >> 2);
    @(negedge clk); cfg_we = 1'b0;
    req_addr = {ROW2, COL2};
    wait_ack();
    req = 1'b0;
    repeat (24) @(negedge clk);
    trace_on = 1'b0;
    analyse();
    chk(c0 - r0 == 2, "R10 running cycle keeps old delay", c0 - r0, 2);
    chk(r1 - e0 == 4, "R10 apply tick lengthens gap", r1 - e0, 4);
    chk(c1 - r1 == 4, "R10 later write wins", c1 - r1, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule